// File: doc/BRIEF.md
# Transmit Jabber and Heartbeat Supervisor

This block watches the transmit-enable level that the squelch logic hands to the transmitter. It decides whether the line driver may actually drive, and it generates the collision-presence signal that goes back to the station. It runs on a fast core clock. A one-cycle timebase strobe arrives at the 10 MHz oscillator rate, and every timer counts these strobes. All terminal counts are parameters, so the real tens-of-milliseconds windows and short scaled windows come from the same RTL.

A transmission that stays enabled for too long trips the jabber latch. The latch blocks the transmitter and raises collision presence. It releases only after the transmit-enable input has been quiet for the full unlatch window. When heartbeat is selected, a short collision burst follows each transmission after a brief delay. A test mode turns jabber protection off. When that mode is left, protection is armed again only after one full unlatch window. While collision presence is active, the collision output is a pulse train locked to the timebase strobe. No data stream passes through the block, so every pin is a plain level and there is no valid/ready handshake.

Top module: `jabber_tx_supervisor`

## Requirements
- R1: After reset, jabber is 0, cd_active is 0, cd_out is 0 and jabber protection is armed.
- R2: tx_ok equals tx_en while jabber is 0, and it is 0 whenever jabber is 1, in the same cycle.
- R3: With protection armed and the mode not test, jabber is still 0 after tx_en has been high through JAB_ACT_TICKS-1 strobes. It is 1 one clock after the JAB_ACT_TICKS-th strobe of a continuous high run. Any low cycle on tx_en restarts the count.
- R4: Once set, jabber clears one clock after tx_en has been low through JAB_RST_TICKS consecutive strobes. Any high cycle on tx_en during jabber restarts that window.
- R5: While jabber is 1, cd_active is 1.
- R6: With mode code 01 (heartbeat on), a falling edge of tx_en outside jabber starts a burst. cd_active rises one clock after the HB_DLY_TICKS-th following strobe and stays high for HB_LEN_TICKS strobes. A rise of tx_en cancels a pending or running burst.
- R7: Mode code 00 (heartbeat off) and the test codes 10 and 11 produce no burst after a transmission.
- R8: With mode bit 1 set (codes 10 and 11, test mode), jabber never asserts. An active jabber clears on the clock after test mode is entered.
- R9: After test mode is left, protection stays disarmed for JAB_RST_TICKS strobes. The jabber count of an ongoing transmission starts only when protection arms again.
- R10: cd_active is the OR of collision, jabber and the heartbeat burst, combinational from collision.
- R11: cd_out is 0 on any clock after a cycle with cd_active low. While cd_active is held high, each strobe gives a high pulse of PULSE_CYC clocks that starts on the clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_10m | input | 1 | One-cycle strobe at the 10 MHz oscillator rate |
| tx_en | input | 1 | Transmit enable from squelch logic |
| collision | input | 1 | Collision detected on the medium |
| mode | input | 2 | 00 heartbeat off, 01 heartbeat on, 1x test (jabber disabled) |
| tx_ok | output | 1 | Transmitter may drive |
| jabber | output | 1 | Jabber latch state |
| cd_active | output | 1 | Collision presence level |
| cd_out | output | 1 | Pulsed collision output |

## Verification
The bench builds the block with an activation window of 20 strobes, an unlatch window of 30, a heartbeat delay of 3, a burst length of 4 and a two-clock pulse, and it strobes every fifth clock. At these counts the whole jabber life cycle fits in a few hundred clocks: trip, release, restart of the release window, test-mode override and re-arming after exit. Heartbeat timing and pulse-train duty can be measured directly at the same scale. Random collision and short transmit runs in heartbeat-off mode exercise the combinational paths.

// File: rtl/jtx_pkg.sv
package jtx_pkg;
  typedef enum logic [1:0] {
    MODE_HB_OFF = 2'b00,
    MODE_HB_ON  = 2'b01,
    MODE_TEST   = 2'b10,
    MODE_TEST_B = 2'b11
  } jtx_mode_e;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'b00,
    HB_WAIT  = 2'b01,
    HB_BURST = 2'b10
  } hb_state_e;

  function automatic logic mode_is_test(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_is_hb(input logic [1:0] m);
    return m == MODE_HB_ON;
  endfunction
endpackage

// File: rtl/jtx_tick_timer.sv
module jtx_tick_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr)                  cnt <= '0;
    else if (tick && cnt != LIM)   cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/jtx_jabber_unit.sv
module jtx_jabber_unit #(
  parameter int JAB_ACT_TICKS = 260000,
  parameter int JAB_RST_TICKS = 4200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_en,
  input  logic test_mode,
  output logic jabber
);
  logic armed;
  logic act_done, rel_done, guard_done;

  // Length of the current continuous transmission
  jtx_tick_timer #(.LIMIT(JAB_ACT_TICKS)) u_act (
    .clk(clk), .rst_n(rst_n),
    .clr(!tx_en || jabber || !armed || test_mode),
    .tick(tick), .done(act_done)
  );

  // Quiet time while latched
  jtx_tick_timer #(.LIMIT(JAB_RST_TICKS)) u_rel (
    .clk(clk), .rst_n(rst_n),
    .clr(!jabber || tx_en),
    .tick(tick), .done(rel_done)
  );

  // Re-arm guard after leaving test mode
  jtx_tick_timer #(.LIMIT(JAB_RST_TICKS)) u_guard (
    .clk(clk), .rst_n(rst_n),
    .clr(test_mode || armed),
    .tick(tick), .done(guard_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b1;
    else if (test_mode) armed <= 1'b0;
    else if (guard_done) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        jabber <= 1'b0;
    else if (test_mode)                jabber <= 1'b0;
    else if (!jabber && armed && act_done) jabber <= 1'b1;
    else if (jabber && rel_done)       jabber <= 1'b0;
  end
endmodule

// File: rtl/jtx_heartbeat_unit.sv
module jtx_heartbeat_unit
  import jtx_pkg::*;
#(
  parameter int HB_DLY_TICKS = 11,
  parameter int HB_LEN_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_en,
  input  logic hb_enable,
  input  logic jabber,
  output logic burst
);
  hb_state_e state;
  logic tx_q;
  logic tx_fall;
  logic dly_done, len_done;

  assign tx_fall = tx_q && !tx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= tx_en;
  end

  jtx_tick_timer #(.LIMIT(HB_DLY_TICKS)) u_dly (
    .clk(clk), .rst_n(rst_n),
    .clr(state != HB_WAIT),
    .tick(tick), .done(dly_done)
  );

  jtx_tick_timer #(.LIMIT(HB_LEN_TICKS)) u_len (
    .clk(clk), .rst_n(rst_n),
    .clr(state != HB_BURST),
    .tick(tick), .done(len_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= HB_IDLE;
    else begin
      unique case (state)
        HB_IDLE:  if (tx_fall && hb_enable && !jabber) state <= HB_WAIT;
        HB_WAIT:  if (tx_en) state <= HB_IDLE;
                  else if (dly_done) state <= HB_BURST;
        HB_BURST: if (tx_en || len_done) state <= HB_IDLE;
        default:  state <= HB_IDLE;
      endcase
    end
  end

  assign burst = (state == HB_BURST);
endmodule

// File: rtl/jtx_cd_gate.sv
module jtx_cd_gate #(
  parameter int PULSE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  output logic cd_out
);
  logic phase_hi;

  generate
    if (PULSE_CYC <= 1) begin : g_single
      assign phase_hi = tick;
    end else begin : g_stretch
      localparam int PW = $clog2(PULSE_CYC);
      logic [PW-1:0] rem;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          rem <= '0;
        else if (tick)       rem <= PW'(PULSE_CYC - 1);
        else if (rem != '0)  rem <= rem - 1'b1;
      end
      assign phase_hi = tick || (rem != '0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cd_out <= 1'b0;
    else        cd_out <= active && phase_hi;
  end
endmodule

// File: rtl/jabber_tx_supervisor.sv
module jabber_tx_supervisor
  import jtx_pkg::*;
#(
  parameter int JAB_ACT_TICKS = 260000,
  parameter int JAB_RST_TICKS = 4200000,
  parameter int HB_DLY_TICKS  = 11,
  parameter int HB_LEN_TICKS  = 10,
  parameter int PULSE_CYC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_10m,
  input  logic       tx_en,
  input  logic       collision,
  input  logic [1:0] mode,
  output logic       tx_ok,
  output logic       jabber,
  output logic       cd_active,
  output logic       cd_out
);
  logic hb_burst;
  logic test_mode;

  assign test_mode = mode_is_test(mode);

  jtx_jabber_unit #(
    .JAB_ACT_TICKS(JAB_ACT_TICKS),
    .JAB_RST_TICKS(JAB_RST_TICKS)
  ) u_jab (
    .clk(clk), .rst_n(rst_n), .tick(tick_10m),
    .tx_en(tx_en), .test_mode(test_mode), .jabber(jabber)
  );

  jtx_heartbeat_unit #(
    .HB_DLY_TICKS(HB_DLY_TICKS),
    .HB_LEN_TICKS(HB_LEN_TICKS)
  ) u_hb (
    .clk(clk), .rst_n(rst_n), .tick(tick_10m),
    .tx_en(tx_en), .hb_enable(mode_is_hb(mode)),
    .jabber(jabber), .burst(hb_burst)
  );

  assign cd_active = collision || jabber || hb_burst;
  assign tx_ok     = tx_en && !jabber;

  jtx_cd_gate #(.PULSE_CYC(PULSE_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .tick(tick_10m),
    .active(cd_active), .cd_out(cd_out)
  );
endmodule

// File: rtl/jtx_sva.sv
module jtx_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_10m,
  input logic       tx_en,
  input logic       collision,
  input logic [1:0] mode,
  input logic       tx_ok,
  input logic       jabber,
  input logic       cd_active,
  input logic       cd_out
);
  // R2
  jabber_blocks_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jabber |-> !tx_ok);

  // R5
  jabber_cd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jabber |-> cd_active);

  // R3
  jabber_needs_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jabber) |-> $past(tx_en));

  // R8
  test_clears_jabber_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |=> !jabber);

  // R10
  coll_presence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> cd_active);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cd_active |=> !cd_out);
endmodule

bind jabber_tx_supervisor jtx_sva u_jtx_sva (.*);

// File: tb/jabber_tx_supervisor_tb.sv
module jabber_tx_supervisor_tb_top;
  localparam int ACT = 20;
  localparam int RST = 30;
  localparam int DLY = 3;
  localparam int LEN = 4;
  localparam int PCY = 2;
  localparam int TP  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic tx_en = 1'b0;
  logic coll = 1'b0;
  logic [1:0] mode = 2'b00;
  logic tx_ok, jabber, cd_active, cd_out;
  int unsigned div = 0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    div  <= (div == TP - 1) ? 0 : div + 1;
    tick <= (div == TP - 1);
  end

  jabber_tx_supervisor #(
    .JAB_ACT_TICKS(ACT), .JAB_RST_TICKS(RST),
    .HB_DLY_TICKS(DLY), .HB_LEN_TICKS(LEN), .PULSE_CYC(PCY)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_10m(tick), .tx_en(tx_en),
    .collision(coll), .mode(mode), .tx_ok(tx_ok), .jabber(jabber),
    .cd_active(cd_active), .cd_out(cd_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit exp_cd(input bit c, input bit j);
    return c | j;
  endfunction

  task automatic count_high(input int n, output int hi_act, output int hi_out);
    hi_act = 0; hi_out = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi_act += int'(cd_active);
      hi_out += int'(cd_out);
    end
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog expired at %0t", $time);
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int a, o;
    void'($urandom(32'h1D5EED));
    cyc(3);
    // R1 reset state
    chk(jabber == 0, "R1 jabber", jabber, 0);
    chk(cd_active == 0, "R1 cd_active", cd_active, 0);
    chk(cd_out == 0, "R1 cd_out", cd_out, 0);
    rst_n = 1'b1;
    cyc(2);

    // R1 armed after reset: jabber trips on a long run
    tx_en = 1'b1;
    cyc(1);
    chk(tx_ok == 1, "R2 tx_ok follows tx_en", tx_ok, 1);
    cyc(TP * (ACT - 1) - 1);
    chk(jabber == 0, "R3 no jabber before limit", jabber, 0);
    cyc(TP * 2);
    chk(jabber == 1, "R3 jabber after limit", jabber, 1);
    chk(tx_ok == 0, "R2 tx blocked in jabber", tx_ok, 0);
    chk(cd_active == 1, "R5 presence in jabber", cd_active, 1);
    count_high(TP * 10, a, o);
    chk(o >= 2 * 10 - 2 && o <= 2 * 10 + 2, "R11 pulse duty in jabber", o, 20);

    // R4 restart of release window
    tx_en = 1'b0;
    cyc(TP * (RST - 5));
    tx_en = 1'b1; cyc(1); tx_en = 1'b0;
    cyc(TP * (RST - 2));
    chk(jabber == 1, "R4 release restarted by tx_en", jabber, 1);
    cyc(TP * 4);
    chk(jabber == 0, "R4 released after quiet window", jabber, 0);

    // R3 a low cycle restarts activation count
    tx_en = 1'b1; cyc(TP * (ACT - 3));
    tx_en = 1'b0; cyc(1);
    tx_en = 1'b1; cyc(TP * (ACT - 3));
    chk(jabber == 0, "R3 count restarted by gap", jabber, 0);
    tx_en = 1'b0; cyc(TP * 2);

    // R6 heartbeat on
    mode = 2'b01;
    tx_en = 1'b1; cyc(TP * 3); tx_en = 1'b0;
    cyc(TP * (DLY - 1));
    chk(cd_active == 0, "R6 no burst before delay", cd_active, 0);
    cyc(TP * 2);
    chk(cd_active == 1, "R6 burst after delay", cd_active, 1);
    count_high(TP * (LEN + 4), a, o);
    chk(a >= TP * (LEN - 2) && a <= TP * LEN, "R6 burst length tail", a, TP * (LEN - 1));
    chk(cd_active == 0, "R6 burst over", cd_active, 0);

    // R6 cancellation by new transmission
    tx_en = 1'b1; cyc(TP * 2); tx_en = 1'b0;
    cyc(TP * 1); tx_en = 1'b1;
    count_high(TP * (DLY + LEN + 2), a, o);
    chk(a == 0, "R6 burst cancelled by tx_en", a, 0);
    tx_en = 1'b0; cyc(TP * (DLY + LEN + 3));

    // R7 heartbeat off and test codes give no burst
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      mode = 2'(m);
      tx_en = 1'b1; cyc(TP * 3); tx_en = 1'b0;
      count_high(TP * (DLY + LEN + 3), a, o);
      chk(a == 0, "R7 no burst in this mode", a, 0);
    end

    // R8 test mode: no jabber on a very long run
    mode = 2'b10;
    tx_en = 1'b1;
    cyc(TP * (ACT + 5));
    chk(jabber == 0, "R8 no jabber in test mode", jabber, 0);
    chk(tx_ok == 1, "R8 tx allowed in test mode", tx_ok, 1);

    // R9 exit waits a full release window before protection
    mode = 2'b00;
    cyc(TP * (ACT + 3));
    chk(jabber == 0, "R9 still disarmed after exit", jabber, 0);
    cyc(TP * (RST - 3) + TP * 2);
    chk(jabber == 1, "R9 armed then trips", jabber, 1);

    // R8 entering test mode clears jabber next clock
    mode = 2'b11;
    cyc(1);
    chk(jabber == 0, "R8 test clears jabber", jabber, 0);
    tx_en = 1'b0;
    mode = 2'b00;
    cyc(TP * (RST + 2));

    // R11 idle output quiet
    count_high(TP * 10, a, o);
    chk(o == 0, "R11 idle output low", o, 0);
    // R10 / R11 collision only
    coll = 1'b1;
    cyc(1);
    chk(cd_active == 1, "R10 collision presence", cd_active, 1);
    count_high(TP * 10, a, o);
    chk(o >= 18 && o <= 22, "R11 pulse duty on collision", o, 20);
    coll = 1'b0;
    cyc(2);
    chk(cd_out == 0, "R11 output low after collision", cd_out, 0);

    // Random: mode 00, short runs, collision toggling
    for (int it = 0; it < 60; it++) begin
      int len;
      len = 1 + int'($urandom_range(39));
      tx_en = 1'($urandom);
      coll  = 1'($urandom);
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        chk(cd_active == exp_cd(coll, 1'b0), "R10 random presence", cd_active, exp_cd(coll, 1'b0));
        chk(tx_ok == tx_en, "R2 random tx_ok", tx_ok, tx_en);
      end
      tx_en = 1'b0;
      cyc(1);
    end
    coll = 1'b0;
    cyc(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule